// File: doc/BRIEF.md
# Pulse-Count Serial Bit Receiver

This block sits on the adapter side of a link where the host can only issue read strobes. The host encodes every bit as a short burst of strobes: one strobe is a 1 and two strobes are a 0. Each burst is followed by an idle recovery gap. The receiver counts the strobes in a burst and times the idle cycles after the last strobe. When the gap reaches its threshold the burst is closed and its length is classified.

Bits arrive most significant first and are shifted into a byte register. A word is sent as four separate bytes. A three-strobe burst is the readiness handshake the host performs before every byte. The host sees the `rdy_o` level on that burst's final read, and the byte is accepted only if the receiver was ready when the burst closed. A twelve-strobe burst asks the receiver to push the last completed byte to a downstream device. Any other burst length is a framing error and throws away the byte being assembled.

Top module: `pulse_burst_rx`

## Requirements
- R1: After reset, `byte_valid_o`, `flush_o` and `frame_err_o` are low, `byte_o` is 0 and `rdy_o` follows `accept_i`.
- R2: A closed burst of one strobe decodes as bit 1 and a burst of two strobes as bit 0. Bits fill the byte MSB first, and the eighth bit loads `byte_o` and pulses `byte_valid_o` for one cycle.
- R3: A burst closes after `GAP_CYCLES` idle cycles following its last strobe, and `byte_valid_o` rises one cycle later. Strobes spaced by fewer than `GAP_CYCLES/2` idle cycles belong to the same burst.
- R4: `rdy_o` is high exactly when `accept_i` is high and no bits of a partial byte are held.
- R5: A three-strobe burst arms byte reception only if `rdy_o` is high when it closes. Bit bursts that arrive while unarmed are ignored: no byte is produced and `byte_o` is unchanged.
- R6: Arming lasts for one byte. After the eighth bit, further bit bursts are ignored until the next readiness burst.
- R7: A twelve-strobe burst pulses `flush_o` for one cycle with `byte_o` holding the last completed byte. It leaves a partially assembled byte intact.
- R8: A burst of 4 to 11 strobes, of 13 or more strobes, or of three strobes while bits are partially held, pulses `frame_err_o` for one cycle, discards the partial byte and disarms.
- R9: `byte_o` changes only in a cycle where `byte_valid_o` is high.
- R10: `byte_valid_o`, `flush_o` and `frame_err_o` are never high together, and each lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe_i | input | 1 | One-cycle pulse per host read strobe |
| accept_i | input | 1 | Downstream can take another byte |
| rdy_o | output | 1 | Readiness level returned on handshake reads |
| byte_o | output | DATA_W | Last completed byte |
| byte_valid_o | output | 1 | One-cycle pulse when a byte completes |
| flush_o | output | 1 | One-cycle pulse requesting output of `byte_o` downstream |
| frame_err_o | output | 1 | One-cycle pulse on an unrecognised burst |

## Verification
The assertions check on every cycle that the three event pulses are exclusive and single-cycle, that `byte_o` moves only with `byte_valid_o`, and that the readiness level returns to `accept_i` once a byte completes. What only the bench scenarios can show is the decoding itself: burst lengths mapping to bit values, the exact closing cycle after the gap, and arming and disarming across handshakes. The same applies to framing errors discarding partial bytes and to flushes leaving a partial byte intact. A scoreboard checks the order and values of received and flushed bytes.

// File: rtl/pbr_pkg.sv
package pbr_pkg;

    typedef enum logic [1:0] {
        BK_BIT   = 2'd0,
        BK_READY = 2'd1,
        BK_FLUSH = 2'd2,
        BK_BAD   = 2'd3
    } burst_kind_e;

    function automatic burst_kind_e classify(input int unsigned len,
                                             input int unsigned ready_len,
                                             input int unsigned flush_len);
        if (len == 1 || len == 2)  return BK_BIT;
        if (len == ready_len)      return BK_READY;
        if (len == flush_len)      return BK_FLUSH;
        return BK_BAD;
    endfunction

endpackage

// File: rtl/pbr_burst_meter.sv
module pbr_burst_meter #(
    parameter int GAP_CYCLES = 16,
    parameter int LEN_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe_i,
    output logic             done_o,
    output logic [LEN_W-1:0] len_o
);
    localparam int GAP_W = $clog2(GAP_CYCLES + 1);
    localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_CYCLES - 1);

    typedef struct packed {
        logic             active;
        logic [LEN_W-1:0] cnt;
        logic [GAP_W-1:0] gap;
        logic             done;
        logic [LEN_W-1:0] len;
    } meter_t;

    meter_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (strobe_i) begin
            st_d.active = 1'b1;
            st_d.gap    = '0;
            if (st_q.cnt != LEN_MAX) st_d.cnt = st_q.cnt + 1'b1;
        end else if (st_q.active) begin
            if (st_q.gap == GAP_LAST) begin
                st_d.done   = 1'b1;
                st_d.len    = st_q.cnt;
                st_d.active = 1'b0;
                st_d.cnt    = '0;
                st_d.gap    = '0;
            end else begin
                st_d.gap = st_q.gap + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_o = st_q.done;
    assign len_o  = st_q.len;

endmodule

// File: rtl/pbr_byte_builder.sv
module pbr_byte_builder
    import pbr_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int LEN_W     = 4,
    parameter int READY_LEN = 3,
    parameter int FLUSH_LEN = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              accept_i,
    output logic              rdy_o,
    output logic [DATA_W-1:0] byte_o,
    output logic              byte_valid_o,
    output logic              flush_o,
    output logic              frame_err_o
);
    localparam int BIT_W = $clog2(DATA_W + 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    typedef struct packed {
        logic              armed;
        logic [BIT_W-1:0]  nbits;
        logic [DATA_W-1:0] shreg;
        logic [DATA_W-1:0] hold;
        logic              valid;
        logic              flush;
        logic              err;
    } build_t;

    build_t st_d, st_q;
    burst_kind_e kind;
    logic        ready_now;
    logic [DATA_W-1:0] shifted;

    assign ready_now = accept_i && (st_q.nbits == '0);

    always_comb begin
        kind    = classify(int'(len_i), READY_LEN, FLUSH_LEN);
        shifted = {st_q.shreg[DATA_W-2:0], (len_i == LEN_W'(1))};
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.flush = 1'b0;
        st_d.err   = 1'b0;
        if (done_i) begin
            unique case (kind)
                BK_BIT: begin
                    if (st_q.armed) begin
                        st_d.shreg = shifted;
                        if (st_q.nbits == LAST_BIT) begin
                            st_d.hold  = shifted;
                            st_d.valid = 1'b1;
                            st_d.nbits = '0;
                            st_d.armed = 1'b0;
                        end else begin
                            st_d.nbits = st_q.nbits + 1'b1;
                        end
                    end
                end
                BK_READY: begin
                    if (st_q.nbits != '0) begin
                        st_d.err   = 1'b1;
                        st_d.nbits = '0;
                        st_d.armed = 1'b0;
                    end else begin
                        st_d.armed = ready_now;
                    end
                end
                BK_FLUSH: st_d.flush = 1'b1;
                default: begin
                    st_d.err   = 1'b1;
                    st_d.nbits = '0;
                    st_d.armed = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdy_o        = ready_now;
    assign byte_o       = st_q.hold;
    assign byte_valid_o = st_q.valid;
    assign flush_o      = st_q.flush;
    assign frame_err_o  = st_q.err;

endmodule

// File: rtl/pulse_burst_rx.sv
module pulse_burst_rx #(
    parameter int GAP_CYCLES = 16,
    parameter int DATA_W     = 8,
    parameter int READY_LEN  = 3,
    parameter int FLUSH_LEN  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_i,
    input  logic              accept_i,
    output logic              rdy_o,
    output logic [DATA_W-1:0] byte_o,
    output logic              byte_valid_o,
    output logic              flush_o,
    output logic              frame_err_o
);
    localparam int LEN_W = $clog2(FLUSH_LEN + 2);

    logic             burst_done;
    logic [LEN_W-1:0] burst_len;

    pbr_burst_meter #(
        .GAP_CYCLES (GAP_CYCLES),
        .LEN_W      (LEN_W)
    ) meter_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (strobe_i),
        .done_o   (burst_done),
        .len_o    (burst_len)
    );

    pbr_byte_builder #(
        .DATA_W    (DATA_W),
        .LEN_W     (LEN_W),
        .READY_LEN (READY_LEN),
        .FLUSH_LEN (FLUSH_LEN)
    ) builder_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .done_i       (burst_done),
        .len_i        (burst_len),
        .accept_i     (accept_i),
        .rdy_o        (rdy_o),
        .byte_o       (byte_o),
        .byte_valid_o (byte_valid_o),
        .flush_o      (flush_o),
        .frame_err_o  (frame_err_o)
    );

endmodule

// File: rtl/pbr_chk.sv
module pbr_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              accept_i,
    input logic              rdy_o,
    input logic [DATA_W-1:0] byte_o,
    input logic              byte_valid_o,
    input logic              flush_o,
    input logic              frame_err_o
);
    // R10
    events_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({byte_valid_o, flush_o, frame_err_o}) <= 1);

    // R2
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_o |=> !byte_valid_o);

    // R10
    err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err_o |=> !frame_err_o);

    // R7
    flush_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> !flush_o);

    // R9
    byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(byte_o) |-> byte_valid_o);

    // R4
    ready_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_o |-> (rdy_o == accept_i));
endmodule

bind pulse_burst_rx pbr_chk #(.DATA_W(DATA_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept_i     (accept_i),
    .rdy_o        (rdy_o),
    .byte_o       (byte_o),
    .byte_valid_o (byte_valid_o),
    .flush_o      (flush_o),
    .frame_err_o  (frame_err_o)
);

// File: tb/pulse_burst_rx_tb_top.sv
module pulse_burst_rx_tb_top;
    localparam int GAP = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strobe = 1'b0;
    logic       accept = 1'b1;
    logic       rdy;
    logic [7:0] byte_out;
    logic       bvalid, flush, ferr;

    int checks = 0;
    int fails = 0;
    int err_seen = 0;
    int err_exp = 0;
    logic [7:0] last_exp = 8'h00;
    logic [7:0] byte_q[$];
    logic [7:0] flush_q[$];

    always #2 clk = ~clk;

    pulse_burst_rx #(.GAP_CYCLES(GAP)) dut_i (
        .clk(clk), .rst_n(rst_n), .strobe_i(strobe), .accept_i(accept),
        .rdy_o(rdy), .byte_o(byte_out), .byte_valid_o(bvalid),
        .flush_o(flush), .frame_err_o(ferr)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: scoreboard side
    always @(negedge clk) begin
        if (rst_n) begin
            if (int'(bvalid) + int'(flush) + int'(ferr) > 1)
                check(0, "R10", {bvalid, flush, ferr}, 0);
            if (bvalid) begin
                if (byte_q.size() == 0) check(0, "R5 R6 unexpected byte", byte_out, 0);
                else begin
                    logic [7:0] e;
                    e = byte_q.pop_front();
                    check(byte_out == e, "R2", byte_out, e);
                end
            end
            if (flush) begin
                if (flush_q.size() == 0) check(0, "R7 unexpected flush", byte_out, 0);
                else begin
                    logic [7:0] f;
                    f = flush_q.pop_front();
                    check(byte_out == f, "R7", byte_out, f);
                end
            end
            if (ferr) err_seen++;
        end
    end

    task automatic pulse();
        @(posedge clk); #1 strobe = 1'b1;
        @(posedge clk); #1 strobe = 1'b0;
    endtask

    task automatic burst(input int n, input int sp);
        for (int i = 0; i < n; i++) begin
            pulse();
            if (i != n - 1) repeat (sp) @(posedge clk);
        end
        repeat (GAP + 4) @(posedge clk);
        #1;
    endtask

    task automatic send_bits(input logic [7:0] v, input int hi, input int lo);
        for (int i = hi; i >= lo; i--) burst(v[i] ? 1 : 2, 0);
    endtask

    // driver: pushes expected bytes
    task automatic send_byte(input logic [7:0] v);
        burst(3, 0);
        byte_q.push_back(v);
        last_exp = v;
        send_bits(v, 7, 0);
    endtask

    task automatic finish_run();
        check(byte_q.size() == 0, "R2 pending bytes", byte_q.size(), 0);
        check(flush_q.size() == 0, "R7 pending flushes", flush_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        // R1 reset state
        check(!bvalid && !flush && !ferr, "R1 pulses", {bvalid, flush, ferr}, 0);
        check(byte_out == 8'h00, "R1 byte", byte_out, 0);
        check(rdy == 1'b1, "R1 rdy", rdy, 1);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;

        // R2 several patterns, words as four bytes
        send_byte(8'hA5);
        send_byte(8'h00);
        send_byte(8'hFF);
        send_byte(8'h3C);
        send_byte(8'hDE); send_byte(8'hAD); send_byte(8'hBE); send_byte(8'hEF);

        // R3 widened intra-burst spacing still forms one zero bit
        burst(3, 0);
        byte_q.push_back(8'h5A);
        last_exp = 8'h5A;
        send_bits(8'h5A, 7, 1);
        pulse();
        repeat (GAP/2 - 2) @(posedge clk);
        pulse();
        repeat (GAP) @(posedge clk);
        #1 check(bvalid == 1'b0, "R3 not yet closed", bvalid, 0);
        @(posedge clk);
        #1 check(bvalid == 1'b1, "R3 valid timing", bvalid, 1);
        repeat (GAP) @(posedge clk);
        #1;

        // R7 flush after a complete byte
        flush_q.push_back(last_exp);
        burst(12, 0);

        // R4 partial byte drops rdy; R7 flush keeps partial byte
        burst(3, 0);
        send_bits(8'h96, 7, 5);
        check(rdy == 1'b0, "R4 partial", rdy, 0);
        flush_q.push_back(last_exp);
        burst(12, 0);
        byte_q.push_back(8'h96);
        send_bits(8'h96, 4, 0);
        last_exp = 8'h96;
        check(rdy == 1'b1, "R4 idle", rdy, 1);

        // R6 after byte completes, bits are ignored without new handshake
        send_bits(8'h11, 7, 0);
        check(byte_out == last_exp, "R6 byte held", byte_out, last_exp);

        // R8 bad burst length discards partial byte
        burst(3, 0);
        send_bits(8'hC3, 7, 6);
        err_exp++;
        burst(5, 0);
        check(rdy == 1'b1, "R8 partial discarded", rdy, 1);
        send_bits(8'hC3, 7, 0);
        check(byte_out == last_exp, "R8 disarmed", byte_out, last_exp);

        // R8 readiness burst mid-byte
        burst(3, 0);
        send_bits(8'h0F, 7, 4);
        err_exp++;
        burst(3, 0);
        check(rdy == 1'b1, "R8 mid-byte handshake", rdy, 1);

        // R8 overlong burst
        err_exp++;
        burst(13, 0);
        check(err_seen == err_exp, "R8 error count", err_seen, err_exp);

        // R5 handshake while not ready does not arm
        accept = 1'b0;
        #1 check(rdy == 1'b0, "R4 accept low", rdy, 0);
        burst(3, 0);
        accept = 1'b1;
        send_bits(8'h77, 7, 0);
        check(byte_out == last_exp, "R5 ignored", byte_out, last_exp);

        // recovered operation
        send_byte(8'h81);
        check(err_seen == err_exp, "R8 final error count", err_seen, err_exp);
        repeat (4) @(posedge clk);
        finish_run();
    end
endmodule